// File: doc/BRIEF.md
# Three-Wire Word-Length-Detecting Serial Receiver

This block receives control words over a three-wire serial link made of an enable line, a serial clock and a data line. While enable is high it shifts in one data bit on each rising edge of the serial clock, most significant bit first, and counts the bits. When enable falls, the bit count alone decides how the collected word is read. The word can be a short tuning word, a long tuning word or a full control word. A word of any other length is thrown away.

The decoded fields drive registered outputs: four band-switch bits, a 15-bit loop divider ratio, a charge-pump current bit, three test bits and a two-bit reference-ratio select. The current reference division ratio is also given as a number. For the two tuning formats the word length also fixes the reference ratio. For the full word, two select bits carried in the word fix it. All three serial inputs are asynchronous to the system clock. They pass through a synchronizer of configurable depth before their edges are detected.

Top module: `tw_rx`

## Requirements
- R1: Serial clock edges that occur while enable is low shift no bit, add nothing to the bit count and change no output.
- R2: Bits are taken on the rising serial-clock edge, first bit most significant. The first four bits of a tuning word land on `band_o[3]` down to `band_o[0]` in that order.
- R3: An 18-bit word loads `band_o` from its first four bits and `div_o[13:0]` from the last fourteen bits, and forces `div_o[14]` to 0. It sets `rsel_o` to 01, so `ratio_o` becomes 512.
- R4: A 19-bit word loads `band_o` from its first four bits and all of `div_o` from the last fifteen bits. It sets `rsel_o` to 10, so `ratio_o` becomes 1024.
- R5: A 27-bit word, taken as bits 26 down to 0 in arrival order, loads `band_o` from 26:23, `div_o` from 22:8, `cp_o` from 7, `test_o` from 6:4 and `rsel_o` from 3:2. Bits 1:0 are ignored. `ratio_o` follows `rsel_o`: 00 gives 640, 01 gives 512, and 10 or 11 gives 1024.
- R6: A word whose length is not 18, 19 or 27 bits is discarded, and every output keeps its previous value.
- R7: After reset all outputs are 0, except `ratio_o`, which is 640 (select 00).
- R8: The bit counter saturates at 31. A window with 32 or more bits (for example 50) is discarded and does not wrap round to a legal length.
- R9: An 18-bit or 19-bit word leaves `cp_o` and `test_o` unchanged.
- R10: Outputs change only after enable falls. While a word is being shifted in, all outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tw_en_i | input | 1 | Serial enable; a word is framed by its high period |
| tw_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| tw_dat_i | input | 1 | Serial data, most significant bit first |
| band_o | output | 4 | Band-switch control bits |
| div_o | output | 15 | Loop divider ratio |
| cp_o | output | 1 | Charge-pump current select |
| test_o | output | 3 | Test-mode bits |
| rsel_o | output | 2 | Reference-ratio select (00=640, 01=512, 1x=1024) |
| ratio_o | output | 11 | Active reference division ratio |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, a 5-bit counter, and field widths that give word lengths of 18, 19 and 27. With these values it can send every window length from 0 to 34 bits, plus a 50-bit window, in two rounds of pseudo-random data. Each result is compared against a field model computed arithmetically in the bench. Because the counter is only five bits wide, the 50-bit window would wrap to 18 if the counter did not saturate, so that window checks saturation directly. Directed words cover all four select codes, the sticky charge-pump and test fields, bit order, clock edges with enable low, and the outputs in the middle of a word.

// File: rtl/tw_rx_pkg.sv
package tw_rx_pkg;

   typedef enum logic [1:0] {
      FMT_NONE  = 2'd0,
      FMT_SHORT = 2'd1,
      FMT_LONG  = 2'd2,
      FMT_FULL  = 2'd3
   } fmt_e;

   localparam int          SEL_W    = 2;
   localparam int          RATIO_W  = 11;
   localparam logic [1:0]  SEL_640  = 2'b00;
   localparam logic [1:0]  SEL_512  = 2'b01;
   localparam logic [1:0]  SEL_1024 = 2'b10;

   function automatic logic [RATIO_W-1:0] ratio_of(input logic [SEL_W-1:0] sel);
      logic [RATIO_W-1:0] r;
      if (sel[1])      r = RATIO_W'(1024);
      else if (sel[0]) r = RATIO_W'(512);
      else             r = RATIO_W'(640);
      return r;
   endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
            end else begin
               stage_q[0] <= d_i;
               for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
            end
         end
         assign q_o = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
   parameter int WORD_W = 27,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_s,
   input  logic              sclk_s,
   input  logic              dat_s,
   output logic [WORD_W-1:0] word_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              done_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic              en_d;
   logic              sclk_d;
   logic              take;
   logic [WORD_W-1:0] word_q;
   logic [CNT_W-1:0]  cnt_q;

   assign take   = en_s & sclk_s & ~sclk_d;
   assign done_o = en_d & ~en_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d   <= 1'b0;
         sclk_d <= 1'b0;
         word_q <= '0;
         cnt_q  <= '0;
      end else begin
         en_d   <= en_s;
         sclk_d <= sclk_s;
         if (done_o) begin
            cnt_q <= '0;
         end else if (take) begin
            word_q <= {word_q[WORD_W-2:0], dat_s};
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign word_o = word_q;
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/tw_decode.sv
module tw_decode
   import tw_rx_pkg::*;
#(
   parameter int BAND_W  = 4,
   parameter int DIV_W   = 15,
   parameter int TEST_W  = 3,
   parameter int SPARE_W = 2,
   parameter int CNT_W   = 5,
   localparam int SEL_LSB   = SPARE_W,
   localparam int TEST_LSB  = SEL_LSB + SEL_W,
   localparam int CP_POS    = TEST_LSB + TEST_W,
   localparam int DIV_LSB   = CP_POS + 1,
   localparam int BAND_LSB  = DIV_LSB + DIV_W,
   localparam int LEN_FULL  = BAND_LSB + BAND_W,
   localparam int LEN_LONG  = BAND_W + DIV_W,
   localparam int LEN_SHORT = LEN_LONG - 1
) (
   input  logic [LEN_FULL-1:0] word_i,
   input  logic [CNT_W-1:0]    cnt_i,
   output fmt_e                fmt_o,
   output logic [BAND_W-1:0]   band_o,
   output logic [DIV_W-1:0]    div_o,
   output logic                cp_o,
   output logic [TEST_W-1:0]   test_o,
   output logic [SEL_W-1:0]    sel_o
);

   always_comb begin
      fmt_o  = FMT_NONE;
      band_o = '0;
      div_o  = '0;
      cp_o   = 1'b0;
      test_o = '0;
      sel_o  = SEL_640;
      if (cnt_i == CNT_W'(LEN_SHORT)) begin
         fmt_o  = FMT_SHORT;
         band_o = word_i[LEN_SHORT-1 -: BAND_W];
         div_o  = {1'b0, word_i[DIV_W-2:0]};
         sel_o  = SEL_512;
      end else if (cnt_i == CNT_W'(LEN_LONG)) begin
         fmt_o  = FMT_LONG;
         band_o = word_i[LEN_LONG-1 -: BAND_W];
         div_o  = word_i[DIV_W-1:0];
         sel_o  = SEL_1024;
      end else if (cnt_i == CNT_W'(LEN_FULL)) begin
         fmt_o  = FMT_FULL;
         band_o = word_i[BAND_LSB +: BAND_W];
         div_o  = word_i[DIV_LSB +: DIV_W];
         cp_o   = word_i[CP_POS];
         test_o = word_i[TEST_LSB +: TEST_W];
         sel_o  = word_i[SEL_LSB +: SEL_W];
      end
   end

endmodule

// File: rtl/tw_rx.sv
module tw_rx
   import tw_rx_pkg::*;
#(
   parameter int BAND_W      = 4,
   parameter int DIV_W       = 15,
   parameter int TEST_W      = 3,
   parameter int SPARE_W     = 2,
   parameter int CNT_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tw_en_i,
   input  logic               tw_clk_i,
   input  logic               tw_dat_i,
   output logic [BAND_W-1:0]  band_o,
   output logic [DIV_W-1:0]   div_o,
   output logic               cp_o,
   output logic [TEST_W-1:0]  test_o,
   output logic [SEL_W-1:0]   rsel_o,
   output logic [RATIO_W-1:0] ratio_o
);

   localparam int WORD_W  = BAND_W + DIV_W + 1 + TEST_W + SEL_W + SPARE_W;
   localparam int CNT_TOP = (1 << CNT_W) - 1;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("tw_rx: SYNC_STAGES must not be negative");
      end
      if (CNT_TOP <= WORD_W) begin : g_bad_cnt
         $error("tw_rx: CNT_W too narrow to tell overlong words apart");
      end
      if (DIV_W < 2 || BAND_W < 1 || TEST_W < 1) begin : g_bad_fields
         $error("tw_rx: field widths out of range");
      end
   endgenerate

   logic              en_s;
   logic              sclk_s;
   logic              dat_s;
   logic [WORD_W-1:0] shift_word;
   logic [CNT_W-1:0]  bit_cnt;
   logic              word_done;
   fmt_e              dec_fmt;
   logic [BAND_W-1:0] dec_band;
   logic [DIV_W-1:0]  dec_div;
   logic              dec_cp;
   logic [TEST_W-1:0] dec_test;
   logic [SEL_W-1:0]  dec_sel;
   logic              load;

   tw_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({tw_en_i, tw_clk_i, tw_dat_i}),
      .q_o   ({en_s, sclk_s, dat_s})
   );

   tw_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) shift_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_s   (en_s),
      .sclk_s (sclk_s),
      .dat_s  (dat_s),
      .word_o (shift_word),
      .cnt_o  (bit_cnt),
      .done_o (word_done)
   );

   tw_decode #(
      .BAND_W(BAND_W), .DIV_W(DIV_W), .TEST_W(TEST_W),
      .SPARE_W(SPARE_W), .CNT_W(CNT_W)
   ) dec_i (
      .word_i (shift_word),
      .cnt_i  (bit_cnt),
      .fmt_o  (dec_fmt),
      .band_o (dec_band),
      .div_o  (dec_div),
      .cp_o   (dec_cp),
      .test_o (dec_test),
      .sel_o  (dec_sel)
   );

   assign load = word_done & (dec_fmt != FMT_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         band_o  <= '0;
         div_o   <= '0;
         cp_o    <= 1'b0;
         test_o  <= '0;
         rsel_o  <= SEL_640;
         ratio_o <= ratio_of(SEL_640);
      end else if (load) begin
         band_o  <= dec_band;
         div_o   <= dec_div;
         rsel_o  <= dec_sel;
         ratio_o <= ratio_of(dec_sel);
         if (dec_fmt == FMT_FULL) begin
            cp_o   <= dec_cp;
            test_o <= dec_test;
         end
      end
   end

endmodule

// File: rtl/tw_rx_chk.sv
module tw_rx_chk
   import tw_rx_pkg::*;
#(
   parameter int BAND_W = 4,
   parameter int DIV_W  = 15,
   parameter int TEST_W = 3,
   parameter int CNT_W  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_s,
   input logic               word_done,
   input logic               load,
   input fmt_e               dec_fmt,
   input logic [CNT_W-1:0]   bit_cnt,
   input logic [BAND_W-1:0]  band_o,
   input logic [DIV_W-1:0]   div_o,
   input logic               cp_o,
   input logic [TEST_W-1:0]  test_o,
   input logic [SEL_W-1:0]   rsel_o,
   input logic [RATIO_W-1:0] ratio_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // R10
   hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(band_o) && $stable(div_o) && $stable(cp_o) &&
                 $stable(test_o) && $stable(rsel_o) && $stable(ratio_o)));

   // R3
   short_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && dec_fmt == FMT_SHORT) |=> (div_o[DIV_W-1] == 1'b0 && rsel_o == 2'b01 && ratio_o == 11'd512));

   // R4
   long_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && dec_fmt == FMT_LONG) |=> (rsel_o == 2'b10 && ratio_o == 11'd1024));

   // R9
   sticky_cp_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && dec_fmt != FMT_FULL) |=> ($stable(cp_o) && $stable(test_o)));

   // R1
   idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_s && !word_done) |=> $stable(bit_cnt));

   // R8
   count_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_s && bit_cnt == CNT_MAX) |=> (bit_cnt == CNT_MAX));

   // R5
   ratio_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ratio_o == (rsel_o[1] ? 11'd1024 : (rsel_o[0] ? 11'd512 : 11'd640))));

endmodule

bind tw_rx tw_rx_chk #(
   .BAND_W(BAND_W), .DIV_W(DIV_W), .TEST_W(TEST_W), .CNT_W(CNT_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .en_s      (en_s),
   .word_done (word_done),
   .load      (load),
   .dec_fmt   (dec_fmt),
   .bit_cnt   (bit_cnt),
   .band_o    (band_o),
   .div_o     (div_o),
   .cp_o      (cp_o),
   .test_o    (test_o),
   .rsel_o    (rsel_o),
   .ratio_o   (ratio_o)
);

// File: tb/tw_rx_tb_top.sv
module tw_rx_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tw_en = 1'b0;
   logic        tw_clk = 1'b0;
   logic        tw_dat = 1'b0;
   logic [3:0]  band_o;
   logic [14:0] div_o;
   logic        cp_o;
   logic [2:0]  test_o;
   logic [1:0]  rsel_o;
   logic [10:0] ratio_o;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   logic [3:0]  e_band = '0;
   logic [14:0] e_div  = '0;
   logic        e_cp   = 1'b0;
   logic [2:0]  e_test = '0;
   logic [1:0]  e_sel  = '0;
   logic [63:0] rng    = 64'h9E37_79B9_7F4A_7C15;

   always #4 clk = ~clk;

   tw_rx dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tw_en_i  (tw_en),
      .tw_clk_i (tw_clk),
      .tw_dat_i (tw_dat),
      .band_o   (band_o),
      .div_o    (div_o),
      .cp_o     (cp_o),
      .test_o   (test_o),
      .rsel_o   (rsel_o),
      .ratio_o  (ratio_o)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_ratio(input logic [1:0] s);
      return s[1] ? 1024 : (s[0] ? 512 : 640);
   endfunction

   task automatic check_all(input string req);
      chk(req, "band",  int'(band_o),  int'(e_band));
      chk(req, "div",   int'(div_o),   int'(e_div));
      chk(req, "cp",    int'(cp_o),    int'(e_cp));
      chk(req, "test",  int'(test_o),  int'(e_test));
      chk(req, "rsel",  int'(rsel_o),  int'(e_sel));
      chk(req, "ratio", int'(ratio_o), exp_ratio(e_sel));
   endtask

   function automatic void model(input logic [63:0] v, input int len);
      case (len)
         18: begin
            e_band = v[17:14];
            e_div  = {1'b0, v[13:0]};
            e_sel  = 2'b01;
         end
         19: begin
            e_band = v[18:15];
            e_div  = v[14:0];
            e_sel  = 2'b10;
         end
         27: begin
            e_band = v[26:23];
            e_div  = v[22:8];
            e_cp   = v[7];
            e_test = v[6:4];
            e_sel  = v[3:2];
         end
         default: ;
      endcase
   endfunction

   task automatic send_word(input logic [63:0] v, input int len, input bit midchk);
      tw_en = 1'b1;
      tick(3);
      for (int i = len - 1; i >= 0; i--) begin
         tw_dat = v[i];
         tick(2);
         tw_clk = 1'b1;
         tick(2);
         tw_clk = 1'b0;
         if (midchk && i == len / 2) check_all("R10");
      end
      tick(2);
      tw_en = 1'b0;
      tick(8);
   endtask

   function automatic logic [63:0] next_rng();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      return rng;
   endfunction

   function automatic logic [63:0] full_word(input int band, input int dv, input int cp,
                                             input int tst, input int sel, input int spare);
      return (64'(band) << 23) | (64'(dv) << 8) | (64'(cp) << 7) |
             (64'(tst) << 4) | (64'(sel) << 2) | 64'(spare);
   endfunction

   initial begin : main
      logic [63:0] v;
      tick(5);
      // R7: reset values
      check_all("R7");
      rst_n = 1'b1;
      tick(4);
      check_all("R7");

      // R1: serial clock activity with enable low is ignored
      for (int k = 0; k < 10; k++) begin
         tw_dat = 1'b1;
         tick(2);
         tw_clk = 1'b1;
         tick(2);
         tw_clk = 1'b0;
      end
      tick(6);
      check_all("R1");
      v = 64'h2_A5C3;
      send_word(v, 18, 1'b0);
      model(v, 18);
      check_all("R1");

      // R2: bit order into band field
      v = 64'(18'b1000_00000000000001);
      send_word(v, 18, 1'b0);
      model(v, 18);
      chk("R2", "band", int'(band_o), 8);
      chk("R2", "div",  int'(div_o), 1);

      // R5: every select code through a full word
      for (int s = 0; s < 4; s++) begin
         v = full_word(s + 3, 1000 * (s + 1), s & 1, 7 - s, s, 3);
         send_word(v, 27, 1'b0);
         model(v, 27);
         check_all("R5");
      end

      // R9: tuning words keep charge-pump and test bits
      v = full_word(5, 12345, 1, 5, 0, 0);
      send_word(v, 27, 1'b0);
      model(v, 27);
      v = 64'h7_1234;
      send_word(v, 19, 1'b1);
      model(v, 19);
      chk("R9", "cp",   int'(cp_o),   1);
      chk("R9", "test", int'(test_o), 5);
      v = 64'h1_0F0F;
      send_word(v, 18, 1'b0);
      model(v, 18);
      chk("R9", "cp",   int'(cp_o),   1);
      chk("R9", "test", int'(test_o), 5);

      // Length sweep: R3 R4 R5 R6 R8
      for (int round = 0; round < 2; round++) begin
         for (int len = 0; len <= 35; len++) begin
            int l;
            string tag;
            l = (len == 35) ? 50 : len;
            v = next_rng();
            send_word(v, l, (l == 19 && round == 0));
            model(v, l);
            if (l == 18)      tag = "R3";
            else if (l == 19) tag = "R4";
            else if (l == 27) tag = "R5";
            else if (l == 50) tag = "R8";
            else              tag = "R6";
            check_all(tag);
         end
      end

      // R8: 50 bits whose low 18 would be a legal short word
      v = 64'h0003_FFFF_FFFF_FFFF;
      send_word(v, 50, 1'b0);
      check_all("R8");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule